// File: doc/BRIEF.md
# SPI Master Pin Timing Adjuster

This stage sits between an SPI master's shift engine and its pads. On the way out it holds back the serial data by zero to three system-clock cycles. On the way in it delays the raw input pin by zero to three cycles. It then picks the instant at which the input bit is captured. That instant can be two cycles or one cycle before the engine's nominal sample strobe, exactly on it, or one cycle after it. With these settings the round-trip skew of board traces and pad cells can be absorbed without changing the serial clock.

Each captured bit goes to the shift register together with a one-cycle valid pulse. The three settings are copied into internal registers only while the engine reports the bus as idle, so a transfer always runs with one fixed timing. While the bus is idle, the outgoing pin keeps the last value it drove.

Top module: `spi_iotime`

## Requirements
- R1: While reset is asserted, rx_bit and rx_vld are 0. With bus_active low during reset, mosi_pad is 0.
- R2: The output delay field mo_dly selects n = 0, 1, 2 or 3. While bus_active stays high, mosi_pad in cycle t equals mosi_core from cycle t-n.
- R3: The input delay field mi_dly selects m = 0, 1, 2 or 3. The captured input is miso_pad as it was m cycles earlier than the capture instant.
- R4: The capture field cap_sel is encoded as follows: 0 captures two cycles before the cycle in which sample_stb is high, 1 captures one cycle before it, 2 captures in that cycle, and 3 captures one cycle after it. With strobe cycle k, rx_bit takes miso_pad from cycle k + cap_sel - 2 - m.
- R5: rx_vld is a one-cycle pulse. It is high in the cycle after the strobe for cap_sel 0 to 2, and two cycles after the strobe for cap_sel 3. rx_bit changes only together with such a pulse.
- R6: The three fields are taken in at a clock edge only while bus_active is low. Changes while bus_active is high have no effect on mosi_pad, rx_bit or rx_vld.
- R7: After reset the settings are mo_dly 0, mi_dly 0 and cap_sel 0 (two cycles early), until the fields are first taken in.
- R8: While bus_active is low, mosi_pad holds the value it had in the last cycle that bus_active was high, whatever mosi_core does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_active | input | 1 | Shift engine busy; settings frozen while high |
| cfg_mo_dly | input | 2 | Output delay in cycles (0 to 3) |
| cfg_mi_dly | input | 2 | Input delay in cycles (0 to 3) |
| cfg_cap | input | 2 | Capture instant code (see R4) |
| mosi_core | input | MOSI_W | Serial output data from the shift engine |
| sample_stb | input | 1 | Nominal input sample strobe from the shift engine |
| miso_pad | input | 1 | Raw serial input pin |
| mosi_pad | output | MOSI_W | Delayed serial output toward the pin |
| rx_bit | output | 1 | Captured input bit for the shift register |
| rx_vld | output | 1 | One-cycle pulse marking a new rx_bit |

## Verification
The main function is driven with random serial streams in both directions while the strobe fires every fourth cycle. A set of setting combinations is used, and together they cover each output delay, each input delay and each capture code. Because the input stream changes from cycle to cycle, a capture that is off by a single cycle in either direction shows up as a wrong bit. The late code is also told apart by the extra cycle of valid latency. Combinations that give the same net input offset by different means (for example an input delay of 1 with code 1, against no delay with code 0) show that delay and capture add up as stated. Directed runs hold bus_active high from reset with non-default fields, scramble the fields in the middle of each transfer, and toggle mosi_core during idle. These runs separate the reset defaults, the settings freeze and the output hold from the normal delay behaviour.

// File: rtl/spi_iotime_pkg.sv
package spi_iotime_pkg;

   localparam int CFG_W    = 2;
   localparam int DLY_MAX  = (1 << CFG_W) - 1;
   localparam int CAP_HIST = 2;

   typedef enum logic [CFG_W-1:0] {
      CAP_EARLY2  = 2'd0,
      CAP_EARLY1  = 2'd1,
      CAP_NOMINAL = 2'd2,
      CAP_LATE1   = 2'd3
   } cap_mode_e;

   typedef struct packed {
      logic [CFG_W-1:0] mo_dly;
      logic [CFG_W-1:0] mi_dly;
      cap_mode_e        cap;
   } iotime_cfg_t;

   localparam iotime_cfg_t CFG_RESET = '{mo_dly: '0, mi_dly: '0, cap: CAP_EARLY2};

endpackage

// File: rtl/spi_iotime_dly.sv
module spi_iotime_dly
   import spi_iotime_pkg::*;
#(
   parameter int W     = 1,
   parameter int DEPTH = DLY_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CFG_W-1:0] sel,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout
);

   if (DEPTH < 1 || DEPTH > DLY_MAX) begin : g_bad_depth
      $error("spi_iotime_dly: DEPTH must lie in 1..%0d", DLY_MAX);
   end
   if (W < 1) begin : g_bad_width
      $error("spi_iotime_dly: W must be at least 1");
   end

   logic [W-1:0] stage [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  stage[g] <= '0;
            else if (en) stage[g] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  stage[g] <= '0;
            else if (en) stage[g] <= stage[g-1];
         end
      end
   end

   // Tap select; a code beyond DEPTH clamps to the deepest stage.
   always_comb begin
      dout = din;
      for (int k = 0; k < DEPTH; k++) begin
         if (int'(sel) >= k + 1) dout = stage[k];
      end
   end

   // R2: a one-cycle tap returns the input of the previous enabled cycle
   assert_tap1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel == CFG_W'(1) && $past(sel) == CFG_W'(1) && $past(en))
      |-> dout == $past(din));

endmodule

// File: rtl/spi_iotime_cap.sv
module spi_iotime_cap
   import spi_iotime_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cap_mode_e cap_sel,
   input  logic      in_bit,
   input  logic      stb,
   output logic      rx_bit,
   output logic      rx_vld
);

   logic hist [CAP_HIST];
   logic stb_d;
   logic pick;
   logic fire;

   for (genvar g = 0; g < CAP_HIST; g++) begin : g_hist
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist[g] <= 1'b0;
            else        hist[g] <= in_bit;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist[g] <= 1'b0;
            else        hist[g] <= hist[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_d <= 1'b0;
      else        stb_d <= stb;
   end

   // Early codes look back into the history, nominal and late take the live bit.
   always_comb begin
      unique case (cap_sel)
         CAP_EARLY2: pick = hist[CAP_HIST-1];
         CAP_EARLY1: pick = hist[0];
         default:    pick = in_bit;
      endcase
   end

   assign fire = (cap_sel == CAP_LATE1) ? stb_d : stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_bit <= 1'b0;
         rx_vld <= 1'b0;
      end else begin
         rx_vld <= fire;
         if (fire) rx_bit <= pick;
      end
   end

   // R5: a valid pulse always traces back to a strobe one or two cycles earlier
   assert_vld_after_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld |-> ($past(stb) || $past(stb, 2)));

   // R5: the captured bit moves only together with a valid pulse
   assert_bit_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |-> $stable(rx_bit));

   // R4: nominal code captures the input present in the strobe cycle
   assert_nominal_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && $past(cap_sel) == CAP_NOMINAL && $past(stb)) |-> rx_bit == $past(in_bit));

endmodule

// File: rtl/spi_iotime.sv
module spi_iotime
   import spi_iotime_pkg::*;
#(
   parameter int MOSI_W = 1,
   parameter int DLY_N  = DLY_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_active,
   input  logic [1:0]        cfg_mo_dly,
   input  logic [1:0]        cfg_mi_dly,
   input  logic [1:0]        cfg_cap,
   input  logic [MOSI_W-1:0] mosi_core,
   input  logic              sample_stb,
   input  logic              miso_pad,
   output logic [MOSI_W-1:0] mosi_pad,
   output logic              rx_bit,
   output logic              rx_vld
);

   if (DLY_N < 1 || DLY_N > DLY_MAX) begin : g_bad_dly
      $error("spi_iotime: DLY_N must lie in 1..%0d", DLY_MAX);
   end
   if (MOSI_W < 1) begin : g_bad_w
      $error("spi_iotime: MOSI_W must be at least 1");
   end

   iotime_cfg_t       cfg_q;
   logic [MOSI_W-1:0] mosi_tap;
   logic [MOSI_W-1:0] mosi_last;
   logic              miso_tap;

   // Settings are taken in only while the bus is idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (!bus_active) begin
         cfg_q.mo_dly <= cfg_mo_dly;
         cfg_q.mi_dly <= cfg_mi_dly;
         cfg_q.cap    <= cap_mode_e'(cfg_cap);
      end
   end

   spi_iotime_dly #(.W(MOSI_W), .DEPTH(DLY_N)) u_mosi_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (bus_active),
      .sel  (cfg_q.mo_dly),
      .din  (mosi_core),
      .dout (mosi_tap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mosi_last <= '0;
      else if (bus_active) mosi_last <= mosi_tap;
   end

   assign mosi_pad = bus_active ? mosi_tap : mosi_last;

   spi_iotime_dly #(.W(1), .DEPTH(DLY_N)) u_miso_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .sel  (cfg_q.mi_dly),
      .din  (miso_pad),
      .dout (miso_tap)
   );

   spi_iotime_cap u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_sel(cfg_q.cap),
      .in_bit (miso_tap),
      .stb    (sample_stb),
      .rx_bit (rx_bit),
      .rx_vld (rx_vld)
   );

   // R6: settings never move after an edge at which the bus was busy
   assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_active) |-> $stable(cfg_q));

   // R8: output pin holds across consecutive idle cycles
   assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_active && !$past(bus_active)) |-> $stable(mosi_pad));

endmodule

// File: tb/spi_iotime_tb.sv
`timescale 1ns/1ps
module spi_iotime_tb;

   localparam int RUN  = 48;
   localparam int NVEC = 8;
   // columns: mo_dly, mi_dly, cap, expected mosi lag, expected miso offset (cap-2-mi)
   localparam int VEC [NVEC][5] = '{
      '{0, 0, 2, 0,  0},
      '{1, 0, 3, 1,  1},
      '{2, 1, 1, 2, -2},
      '{3, 2, 0, 3, -4},
      '{0, 3, 3, 0, -2},
      '{1, 3, 0, 1, -5},
      '{2, 0, 1, 2, -1},
      '{3, 1, 2, 3, -1}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_active;
   logic [1:0] cfg_mo_dly, cfg_mi_dly, cfg_cap;
   logic       mosi_core, sample_stb, miso_pad;
   logic       mosi_pad, rx_bit, rx_vld;

   logic mo_h [RUN];
   logic mi_h [RUN];
   logic st_h [RUN];

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   spi_iotime u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_active(bus_active),
      .cfg_mo_dly(cfg_mo_dly),
      .cfg_mi_dly(cfg_mi_dly),
      .cfg_cap   (cfg_cap),
      .mosi_core (mosi_core),
      .sample_stb(sample_stb),
      .miso_pad  (miso_pad),
      .mosi_pad  (mosi_pad),
      .rx_bit    (rx_bit),
      .rx_vld    (rx_vld)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Applies fields (a_*) during an optional idle cycle, then runs one busy transfer.
   task automatic run_vec(input int a_o, input int a_i, input int a_c,
                          input int lag, input int off, input int late, input bit do_idle);
      if (do_idle) begin
         @(negedge clk);
         bus_active = 1'b0;
         sample_stb = 1'b0;
         cfg_mo_dly = 2'(a_o);
         cfg_mi_dly = 2'(a_i);
         cfg_cap    = 2'(a_c);
      end
      for (int t = 0; t < RUN; t++) begin
         int d;
         logic ev;
         @(negedge clk);
         bus_active = 1'b1;
         if (t == 20) begin
            cfg_mo_dly = ~cfg_mo_dly;
            cfg_mi_dly = ~cfg_mi_dly;
            cfg_cap    = ~cfg_cap;
         end
         mosi_core  = 1'($urandom);
         miso_pad   = 1'($urandom);
         sample_stb = (t >= 8 && t % 4 == 0 && t < RUN - 4);
         mo_h[t] = mosi_core;
         mi_h[t] = miso_pad;
         st_h[t] = sample_stb;
         #1;
         if (t >= lag)
            chk(t > 20 ? "R6 mosi after busy field change" : "R2 mosi delay", mosi_pad, mo_h[t-lag]);
         d  = 1 + late;
         ev = (t >= d) ? st_h[t-d] : 1'b0;
         chk("R5 valid pulse timing", rx_vld, ev);
         if (ev)
            chk(t > 20 ? "R6 capture after busy field change" : "R3 R4 captured bit",
                rx_bit, mi_h[t-d+off]);
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      bus_active = 1'b0;
      cfg_mo_dly = 2'd3;
      cfg_mi_dly = 2'd3;
      cfg_cap    = 2'd3;
      mosi_core  = 1'b1;
      sample_stb = 1'b1;
      miso_pad   = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 mosi_pad in reset", mosi_pad, 1'b0);
      chk("R1 rx_bit in reset", rx_bit, 1'b0);
      chk("R1 rx_vld in reset", rx_vld, 1'b0);
      // busy from before release: fields 3/3/3 must not be taken in (R7 defaults apply)
      @(negedge clk);
      bus_active = 1'b1;
      sample_stb = 1'b0;
      mosi_core  = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_vec(3, 3, 3, 0, -2, 0, 1'b0);   // R7 expected: lag 0, two cycles early

      for (int v = 0; v < NVEC; v++)
         run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                 (VEC[v][2] == 3) ? 1 : 0, 1'b1);

      // R8: hold last driven value while idle, even as mosi_core toggles
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         bus_active = 1'b0;
         sample_stb = 1'b0;
         mosi_core  = (k % 2 == 0) ? ~mo_h[RUN-4] : mo_h[RUN-4];
         #1;
         chk("R8 idle hold", mosi_pad, mo_h[RUN-1-3]);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule